// File: doc/BRIEF.md
# Linear Address Tag Masking Unit

This block sits in the address path of a 64-bit core, ahead of translation. It takes a linear address and works out whether the upper bits of that address carry software metadata that translation must ignore. When they do, it overwrites those bits with copies of the highest translated bit. It then checks the cleaned address for canonical form and returns the address together with a fault flag.

Three inputs decide which bits are treated as metadata. The first is pointer bit 63, which classes the address as user or supervisor. The second is a pair of user masking enables taken from the page-table base register, where the wide enable sits at bit 62 and the narrow enable at bit 61. The third is a supervisor masking enable taken from bit 28 of a control register. The paging depth (4-level or 5-level) also plays a part.

Instruction fetches are never masked. The current privilege level has no bearing on the user or supervisor choice. The result is registered and appears one cycle after a valid input.

Top module: `addr_untag_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid input, `out_valid`, `out_fault` and `out_addr` are all zero.
- R2: A result appears on the outputs with `out_valid` high exactly one clock edge after `in_valid` is sampled high. In a cycle that follows an edge where `in_valid` was low, `out_valid` is low.
- R3: For a data access with bit 63 = 0 and `pt_u57_en` = 1, bits 62:57 are replaced with copies of bit 56. This holds whatever the value of `pt_u48_en`.
- R4: For a data access with bit 63 = 0, `pt_u48_en` = 1 and `pt_u57_en` = 0, bits 62:48 are replaced with copies of bit 47.
- R5: For a data access with bit 63 = 0 and both user enables low, the address passes through unchanged.
- R6: For a data access with bit 63 = 1 and `sup_mask_en` = 1, 4-level paging (`five_level` = 0) replaces bits 62:48 with bit 47, and 5-level paging replaces bits 62:57 with bit 56. With `sup_mask_en` = 0, the address passes through unchanged.
- R7: Bit 63 alone picks between the user and supervisor rules. The user enables have no effect on an address with bit 63 = 1, and `sup_mask_en` has no effect on an address with bit 63 = 0. Bit 63 is never altered.
- R8: When `in_is_fetch` = 1, no masking is applied and the full canonical check for the current paging depth is made.
- R9: `out_fault` is 1 exactly when any bit of the cleaned address from 62 down to the top translated bit differs from bit 63. The top translated bit is bit 47 under 4-level paging or under the 48-bit masking mode, and bit 56 otherwise.
- R10: With 5-level paging and the user 48-bit masking mode in effect, bits 56:48 are treated as metadata. The canonical check then covers bits 63:47.
- R11: In a valid result with `out_fault` = 0, bits 63:56 of `out_addr` are all equal, so every reported address that does not fault is canonical with its metadata cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input address is valid this cycle |
| in_addr | input | 64 | Linear address, possibly tagged |
| in_is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| pt_u48_en | input | 1 | User 48-bit masking enable (page-table base bit 62) |
| pt_u57_en | input | 1 | User 57-bit masking enable (page-table base bit 61), takes priority |
| sup_mask_en | input | 1 | Supervisor masking enable (control register bit 28) |
| five_level | input | 1 | 1 = 5-level paging, 0 = 4-level paging |
| out_valid | output | 1 | Registered result valid |
| out_addr | output | 64 | Cleaned address |
| out_fault | output | 1 | Canonical check failed |

## Verification
The path has one register, so every result is due at the first rising edge after the input was presented. The bench drives each input on a falling edge and samples the outputs on the next falling edge. It then drops `in_valid` and, for R2, looks one further falling edge later to confirm that `out_valid` has returned low. Expected addresses and fault flags come from a reference function in the bench written from the requirements, backed up by hand-computed literals for each mode boundary.

// File: rtl/addr_untag_pkg.sv
package addr_untag_pkg;

    localparam int unsigned ADDR_W = 64;

    typedef enum logic [1:0] {
        MASK_OFF = 2'd0,
        MASK_W48 = 2'd1,
        MASK_W57 = 2'd2
    } mask_mode_e;

    typedef struct packed {
        logic              valid;
        logic              fault;
        logic [ADDR_W-1:0] addr;
    } untag_result_t;

endpackage

// File: rtl/untag_mode_sel.sv
module untag_mode_sel
    import addr_untag_pkg::*;
(
    input  logic       ptr_top,
    input  logic       is_fetch,
    input  logic       u48_en,
    input  logic       u57_en,
    input  logic       sup_en,
    input  logic       five_level,
    output mask_mode_e mode
);

    mask_mode_e user_mode;
    mask_mode_e sup_mode;

    // User side: the narrow (57) enable wins over the wide (48) one.
    always_comb begin
        if (u57_en) begin
            user_mode = MASK_W57;
        end else if (u48_en) begin
            user_mode = MASK_W48;
        end else begin
            user_mode = MASK_OFF;
        end
    end

    // Supervisor side: paging depth picks the width.
    always_comb begin
        if (!sup_en) begin
            sup_mode = MASK_OFF;
        end else if (five_level) begin
            sup_mode = MASK_W57;
        end else begin
            sup_mode = MASK_W48;
        end
    end

    always_comb begin
        if (is_fetch) begin
            mode = MASK_OFF;
        end else if (ptr_top) begin
            mode = sup_mode;
        end else begin
            mode = user_mode;
        end
    end

endmodule

// File: rtl/untag_fill.sv
module untag_fill
    import addr_untag_pkg::*;
#(
    parameter int unsigned AW     = 64,
    parameter int unsigned LO_TOP = 47,
    parameter int unsigned HI_TOP = 56
) (
    input  logic [AW-1:0] addr_in,
    input  mask_mode_e    mode,
    output logic [AW-1:0] addr_out
);

    localparam int unsigned SIGN_BIT = AW - 1;

    for (genvar i = 0; i < AW; i++) begin : g_bit
        if (i == SIGN_BIT || i <= LO_TOP) begin : g_keep
            assign addr_out[i] = addr_in[i];
        end else if (i > HI_TOP) begin : g_both
            always_comb begin
                unique case (mode)
                    MASK_W48: addr_out[i] = addr_in[LO_TOP];
                    MASK_W57: addr_out[i] = addr_in[HI_TOP];
                    default:  addr_out[i] = addr_in[i];
                endcase
            end
        end else begin : g_wide_only
            assign addr_out[i] = (mode == MASK_W48) ? addr_in[LO_TOP] : addr_in[i];
        end
    end

endmodule

// File: rtl/untag_canon_chk.sv
module untag_canon_chk #(
    parameter int unsigned AW     = 64,
    parameter int unsigned LO_TOP = 47,
    parameter int unsigned HI_TOP = 56
) (
    input  logic [AW-1:LO_TOP] upper,
    input  logic               narrow_top,
    output logic               fault
);

    localparam int unsigned SPAN   = AW - 1 - LO_TOP;
    localparam int unsigned HI_OFF = HI_TOP - LO_TOP;

    logic [SPAN-1:0] mismatch;
    logic [SPAN-1:0] hi_sel;

    for (genvar j = 0; j < SPAN; j++) begin : g_cmp
        assign mismatch[j] = upper[LO_TOP + j] ^ upper[AW-1];
        assign hi_sel[j]   = (j >= HI_OFF);
    end

    assign fault = narrow_top ? (|mismatch) : (|(mismatch & hi_sel));

endmodule

// File: rtl/addr_untag_unit.sv
module addr_untag_unit
    import addr_untag_pkg::*;
#(
    parameter int unsigned LO_TOP = 47,
    parameter int unsigned HI_TOP = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_is_fetch,
    input  logic              pt_u48_en,
    input  logic              pt_u57_en,
    input  logic              sup_mask_en,
    input  logic              five_level,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_fault
);

    mask_mode_e        mode;
    logic [ADDR_W-1:0] clean_addr;
    logic              narrow_top;
    logic              canon_fault;
    untag_result_t     res_d;
    untag_result_t     res_q;

    untag_mode_sel u_mode (
        .ptr_top    (in_addr[ADDR_W-1]),
        .is_fetch   (in_is_fetch),
        .u48_en     (pt_u48_en),
        .u57_en     (pt_u57_en),
        .sup_en     (sup_mask_en),
        .five_level (five_level),
        .mode       (mode)
    );

    untag_fill #(
        .AW     (ADDR_W),
        .LO_TOP (LO_TOP),
        .HI_TOP (HI_TOP)
    ) u_fill (
        .addr_in  (in_addr),
        .mode     (mode),
        .addr_out (clean_addr)
    );

    assign narrow_top = (mode == MASK_W48) || !five_level;

    untag_canon_chk #(
        .AW     (ADDR_W),
        .LO_TOP (LO_TOP),
        .HI_TOP (HI_TOP)
    ) u_canon (
        .upper      (clean_addr[ADDR_W-1:LO_TOP]),
        .narrow_top (narrow_top),
        .fault      (canon_fault)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.addr  = clean_addr;
            res_d.fault = canon_fault;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_addr  = res_q.addr;
    assign out_fault = res_q.fault;

endmodule

// File: rtl/addr_untag_unit_chk.sv
module addr_untag_unit_chk #(
    parameter int unsigned AW     = 64,
    parameter int unsigned HI_TOP = 56
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [AW-1:0] in_addr,
    input logic          in_is_fetch,
    input logic          pt_u48_en,
    input logic          pt_u57_en,
    input logic          sup_mask_en,
    input logic          out_valid,
    input logic [AW-1:0] out_addr,
    input logic          out_fault
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    always_comb begin
        if (!rst_n) begin
            a_r1_reset_clear : assert (!out_valid && !out_fault && out_addr == '0);
        end
    end

    a_r2_valid_latency : assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (out_valid == $past(in_valid)));

    a_r3_narrow_fill : assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(in_valid && !in_is_fetch && !in_addr[AW-1] && pt_u57_en))
        |-> (out_addr[AW-2:HI_TOP+1] == {(AW-2-HI_TOP){$past(in_addr[HI_TOP])}}));

    a_r5_user_pass : assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(in_valid && !in_addr[AW-1] && !pt_u48_en && !pt_u57_en))
        |-> (out_addr == $past(in_addr)));

    a_r6_sup_off_pass : assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(in_valid && in_addr[AW-1] && !sup_mask_en))
        |-> (out_addr == $past(in_addr)));

    a_r7_sign_kept : assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(in_valid)) |-> (out_addr[AW-1] == $past(in_addr[AW-1])));

    a_r8_fetch_pass : assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(in_valid && in_is_fetch)) |-> (out_addr == $past(in_addr)));

    a_r11_clean_canon : assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_fault)
        |-> (out_addr[AW-1:HI_TOP] == '0 || out_addr[AW-1:HI_TOP] == '1));

endmodule

bind addr_untag_unit addr_untag_unit_chk #(
    .AW     (64),
    .HI_TOP (HI_TOP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_addr     (in_addr),
    .in_is_fetch (in_is_fetch),
    .pt_u48_en   (pt_u48_en),
    .pt_u57_en   (pt_u57_en),
    .sup_mask_en (sup_mask_en),
    .out_valid   (out_valid),
    .out_addr    (out_addr),
    .out_fault   (out_fault)
);

// File: tb/addr_untag_unit_bench.sv
module addr_untag_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic        in_is_fetch = 1'b0;
    logic        pt_u48_en = 1'b0;
    logic        pt_u57_en = 1'b0;
    logic        sup_mask_en = 1'b0;
    logic        five_level = 1'b0;
    logic        out_valid;
    logic [63:0] out_addr;
    logic        out_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    addr_untag_unit u_addr_untag_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_addr     (in_addr),
        .in_is_fetch (in_is_fetch),
        .pt_u48_en   (pt_u48_en),
        .pt_u57_en   (pt_u57_en),
        .sup_mask_en (sup_mask_en),
        .five_level  (five_level),
        .out_valid   (out_valid),
        .out_addr    (out_addr),
        .out_fault   (out_fault)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic void ref_model(input logic [63:0] a, input logic u48, input logic u57,
                                      input logic sup, input logic five, input logic fetch,
                                      output logic [63:0] ea, output logic ef);
        int width = 0;
        int top;
        logic [63:0] meta;
        if (!fetch) begin
            if (a[63] == 1'b0) width = u57 ? 57 : (u48 ? 48 : 0);
            else               width = sup ? (five ? 57 : 48) : 0;
        end
        ea = a;
        if (width == 48) meta = 64'h7FFF_0000_0000_0000;
        else if (width == 57) meta = 64'h7E00_0000_0000_0000;
        else meta = '0;
        if (width != 0) ea = (a & ~meta) | (a[width-1] ? meta : 64'h0);
        top = (width == 48 || !five) ? 47 : 56;
        ef = 1'b0;
        for (int b = top; b < 63; b++) if (ea[b] != ea[63]) ef = 1'b1;
    endfunction

    task automatic run_one(input string req, input logic [63:0] a, input logic u48,
                           input logic u57, input logic sup, input logic five,
                           input logic fetch);
        logic [63:0] ea;
        logic        ef;
        ref_model(a, u48, u57, sup, five, fetch, ea, ef);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; pt_u48_en = u48; pt_u57_en = u57;
        sup_mask_en = sup; five_level = five; in_is_fetch = fetch;
        @(negedge clk);
        check({req, " valid"}, {63'h0, out_valid}, 64'h1);
        check({req, " addr"}, out_addr, ea);
        check({req, " fault"}, {63'h0, out_fault}, {63'h0, ef});
        in_valid = 1'b0;
    endtask

    task automatic run_lit(input string req, input logic [63:0] a, input logic u48,
                           input logic u57, input logic sup, input logic five,
                           input logic fetch, input logic [63:0] ea, input logic ef);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; pt_u48_en = u48; pt_u57_en = u57;
        sup_mask_en = sup; five_level = five; in_is_fetch = fetch;
        @(negedge clk);
        check({req, " lit addr"}, out_addr, ea);
        check({req, " lit fault"}, {63'h0, out_fault}, {63'h0, ef});
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 valid", {63'h0, out_valid}, 64'h0);
        check("R1 addr", out_addr, 64'h0);
        check("R1 fault", {63'h0, out_fault}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", {63'h0, out_valid}, 64'h0);
    endtask

    task automatic t_latency();
        run_one("R2", 64'h0000_1234_5678_9abc, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R2 drop", {63'h0, out_valid}, 64'h0);
    endtask

    task automatic t_user_narrow();
        run_lit("R3", 64'h7E00_0000_0000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 64'h0, 1'b0);
        run_lit("R3 prio", 64'h3C00_0000_0000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 64'h0, 1'b0);
        run_lit("R3 fill", 64'h2100_0000_0000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                64'h7F00_0000_0000_0000, 1'b1);
    endtask

    task automatic t_user_wide();
        run_lit("R4", 64'h1234_0000_1234_5678, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
                64'h0000_0000_1234_5678, 1'b0);
        run_lit("R10", 64'h0042_1234_5678_9abc, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0,
                64'h0000_1234_5678_9abc, 1'b0);
    endtask

    task automatic t_user_off();
        run_lit("R5 4lvl", 64'h0100_0000_0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0,
                64'h0100_0000_0000_0000, 1'b1);
        run_lit("R5 5lvl", 64'h0080_0000_0000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0,
                64'h0080_0000_0000_0000, 1'b0);
    endtask

    task automatic t_supervisor();
        run_lit("R6 4lvl", 64'hFABC_8000_0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0,
                64'hFFFF_8000_0000_0000, 1'b0);
        run_lit("R6 5lvl", 64'h8100_0000_0000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0,
                64'hFF00_0000_0000_0000, 1'b0);
        run_lit("R6 off", 64'hFABC_8000_0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                64'hFABC_8000_0000_0000, 1'b1);
    endtask

    task automatic t_class();
        run_lit("R7 user bits ignored", 64'hC000_8000_0000_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
                64'hC000_8000_0000_0000, 1'b1);
        run_lit("R7 sup bit ignored", 64'h4000_0000_0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0,
                64'h4000_0000_0000_0000, 1'b1);
    endtask

    task automatic t_fetch();
        run_lit("R8", 64'h7E00_0000_0000_0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
                64'h7E00_0000_0000_0000, 1'b1);
        run_lit("R8 canon", 64'hFFFF_8000_0000_1000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1,
                64'hFFFF_8000_0000_1000, 1'b0);
    endtask

    task automatic t_fault();
        run_lit("R9 narrow in 4lvl", 64'h0010_0000_0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0,
                64'h0010_0000_0000_0000, 1'b1);
        run_lit("R9 bit47", 64'h0000_8000_0000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                64'h0000_8000_0000_0000, 1'b0);
    endtask

    task automatic t_sweep();
        for (int n = 0; n < 300; n++) begin
            logic [63:0] a;
            logic [4:0]  ctl;
            a   = {$urandom, $urandom};
            ctl = 5'($urandom);
            if (ctl[4]) a[47:0] = 48'h0;
            run_one("R11 sweep", a, ctl[0], ctl[1], ctl[2], ctl[3], (n % 7) == 0);
            if (out_valid && !out_fault) begin
                checks++;
                if (!(out_addr[63:56] == 8'h00 || out_addr[63:56] == 8'hFF)) begin
                    errors++;
                    $display("FAIL R11 actual=%h expected=canonical", out_addr);
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_latency();
        t_user_narrow();
        t_user_wide();
        t_user_off();
        t_supervisor();
        t_class();
        t_fetch();
        t_fault();
        t_sweep();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule